// File: doc/BRIEF.md
# Static Memory Strobe Timing Generator

This block drives the chip-select, read-strobe and write-strobe lines of one external static memory bank for a single access at a time. All three lines are active low. Four 32-bit configuration words describe the access: a word of setup delays, a word of pulse widths, a word of cycle lengths and a mode word. Each timing field uses a compressed encoding. A coarse multiplier bit or bit pair is added to a short linear part. The block expands these fields into clock counts. It then runs one cycle counter per access and opens each strobe in a window of that counter.

A master raises `req_start` along with `req_write` to request an access. The request is taken on a clock edge where the block is free. From that edge the counter walks through the decoded cycle length. `done` then pulses for one clock. `xfer_edge` marks the clock in which the strobe that controls the access, chosen per direction by the mode word, returns high. The master uses it to capture read data or to consider a write complete. An external wait input can stall the access in one of two ways. After a read, a programmable turnaround delay holds off the next request. An optimized mode lets a write, or an access to the same bank, skip that delay. The configuration words must stay stable while `busy` is high.

Top module: `smem_strobe_timer`

## Requirements
- R1: Setup fields are bytes of `cfg_setup`: [7:0] write strobe, [15:8] chip select on writes, [23:16] read strobe, [31:24] chip select on reads. A field decodes to 128 x bit5 + bits[4:0]. The first clock after the accepting edge is access cycle 0. A strobe first goes low in the access cycle equal to its decoded setup.
- R2: Pulse fields of `cfg_pulse` use the same byte positions and decode to 256 x bit6 + bits[5:0]. A strobe stays low for that many access cycles. A decoded pulse of 0 never asserts the strobe.
- R3: The write length is `cfg_cycle`[8:0] and the read length is `cfg_cycle`[24:16]. Each decodes to 256 x bits[8:7] + bits[6:0], and 0 is treated as 1. An access of length L with no stalls shows `done` at the (L+1)-th clock after the request is taken.
- R4: A strobe whose setup plus pulse runs past the cycle length is forced high when the access ends. All strobes are high in the `done` clock. `rd_n` stays high during writes and `wr_n` stays high during reads.
- R5: `xfer_edge` is high for one clock, in the first clock where the controlling strobe is high again after being low. On reads, `cfg_mode`[0]=0 selects chip select and 1 selects the read strobe. On writes, `cfg_mode`[1]=0 selects chip select and 1 selects the write strobe.
- R6: `done` is never high in two consecutive clocks. `busy` is high whenever any strobe is low.
- R7: With `cfg_mode`[5:4]=2 (freeze), every clock in which `ext_wait` is high during an access leaves the access counter and all strobes unchanged.
- R8: With `cfg_mode`[5:4]=3 (ready), the access holds on the last low cycle of the read or write strobe while `ext_wait` is high. Values 0 and 1 ignore `ext_wait`.
- R9: After a read, `busy` stays high and requests are refused for `cfg_mode`[19:16]+1 clocks, starting with the `done` clock. No turnaround follows a write.
- R10: With `cfg_mode`[20]=1, a request is accepted during the turnaround when `req_write` or `req_same_bank` is high.
- R11: During reset all strobes are high, and `busy`, `done` and `xfer_edge` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_setup | input | 32 | Packed setup delays |
| cfg_pulse | input | 32 | Packed pulse widths |
| cfg_cycle | input | 32 | Write and read cycle lengths |
| cfg_mode | input | 32 | Completion source, wait mode, turnaround |
| req_start | input | 1 | Request a new access |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| req_same_bank | input | 1 | Request targets the bank just read |
| ext_wait | input | 1 | External wait, active high |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| xfer_edge | output | 1 | Controlling strobe has just risen |
| busy | output | 1 | Access or turnaround in progress |
| done | output | 1 | One-clock end-of-access pulse |

## Verification
The `done` clock of a read is also the first clock of its turnaround. A request raised in that clock must be refused or accepted at that edge, depending on the direction, the bank and the optimized bit. The bench raises requests in exactly that clock, with and without the bypass. It compares the clock count to the next `done` against a turnaround term computed from the mode word. Randomly placed wait windows can also overlap the last strobe cycle and the cycle end. A bench model stepped in lockstep judges every output in every clock.

// File: rtl/smem_pkg.sv
package smem_pkg;

    // Longest decodable access and the widths derived from it
    localparam int CYC_MAX = 3 * 256 + 127;
    localparam int CNT_W   = $clog2(CYC_MAX + 1);
    localparam int TDF_W   = 4;
    localparam int FLT_W   = TDF_W + 1;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [FLT_W-1:0] flt_t;

    typedef enum logic [1:0] {
        WAIT_OFF    = 2'd0,
        WAIT_RSV    = 2'd1,
        WAIT_FREEZE = 2'd2,
        WAIT_READY  = 2'd3
    } wait_mode_e;

    typedef struct packed {
        logic act;      // access in progress
        logic wr;       // direction of current or last access
        cnt_t cnt;      // access cycle index
        flt_t flt;      // turnaround cycles left
        logic done;     // end-of-access pulse
        logic ctl_low;  // controlling strobe was low last clock
    } st_t;

    // coarse bit worth 128, fine part 0..31
    function automatic cnt_t dec_setup(input logic [5:0] f);
        return cnt_t'({f[5], 7'b0}) + cnt_t'(f[4:0]);
    endfunction

    // coarse bit worth 256, fine part 0..63
    function automatic cnt_t dec_pulse(input logic [6:0] f);
        return cnt_t'({f[6], 8'b0}) + cnt_t'(f[5:0]);
    endfunction

    // coarse pair worth 256 each step, fine part 0..127
    function automatic cnt_t dec_cycle(input logic [8:0] f);
        return cnt_t'({f[8:7], 8'b0}) + cnt_t'(f[6:0]);
    endfunction

endpackage

// File: rtl/smem_timing_sel.sv
module smem_timing_sel
    import smem_pkg::*;
(
    input  logic [31:0] cfg_setup,
    input  logic [31:0] cfg_pulse,
    input  logic [31:0] cfg_cycle,
    input  logic [1:0]  cfg_ctl_sel,
    input  logic        is_wr,
    output cnt_t        cs_setup,
    output cnt_t        cs_pulse,
    output cnt_t        dir_setup,
    output cnt_t        dir_pulse,
    output cnt_t        cyc_len,
    output logic        ctl_on_strobe
);

    cnt_t raw_len;

    always_comb begin
        if (is_wr) begin
            cs_setup  = dec_setup(cfg_setup[13:8]);
            dir_setup = dec_setup(cfg_setup[5:0]);
            cs_pulse  = dec_pulse(cfg_pulse[14:8]);
            dir_pulse = dec_pulse(cfg_pulse[6:0]);
            raw_len   = dec_cycle(cfg_cycle[8:0]);
            ctl_on_strobe = cfg_ctl_sel[1];
        end else begin
            cs_setup  = dec_setup(cfg_setup[29:24]);
            dir_setup = dec_setup(cfg_setup[21:16]);
            cs_pulse  = dec_pulse(cfg_pulse[30:24]);
            dir_pulse = dec_pulse(cfg_pulse[22:16]);
            raw_len   = dec_cycle(cfg_cycle[24:16]);
            ctl_on_strobe = cfg_ctl_sel[0];
        end
        cyc_len = (raw_len == '0) ? cnt_t'(1) : raw_len;
    end

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_setup[31:30], cfg_setup[23:22], cfg_setup[15:14],
                               cfg_setup[7:6], cfg_pulse[31], cfg_pulse[23],
                               cfg_pulse[15], cfg_pulse[7], cfg_cycle[31:25],
                               cfg_cycle[15:9]};

endmodule

// File: rtl/smem_strobe_win.sv
module smem_strobe_win
    import smem_pkg::*;
(
    input  logic en,
    input  cnt_t cnt,
    input  cnt_t setup,
    input  cnt_t pulse,
    output logic low
);

    logic [CNT_W:0] win_end;

    assign win_end = {1'b0, setup} + {1'b0, pulse};
    assign low     = en && (cnt >= setup) && ({1'b0, cnt} < win_end);

endmodule

// File: rtl/smem_wait_hold.sv
module smem_wait_hold
    import smem_pkg::*;
(
    input  wait_mode_e mode,
    input  logic       ext_wait,
    input  cnt_t       cnt,
    input  cnt_t       dir_setup,
    input  cnt_t       dir_pulse,
    output logic       hold
);

    logic [CNT_W:0] pulse_end;
    logic           on_last;

    assign pulse_end = {1'b0, dir_setup} + {1'b0, dir_pulse};
    assign on_last   = (dir_pulse != '0) &&
                       (({1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1}) == pulse_end);

    always_comb begin
        unique case (mode)
            WAIT_FREEZE: hold = ext_wait;
            WAIT_READY:  hold = ext_wait && on_last;
            default:     hold = 1'b0;
        endcase
    end

endmodule

// File: rtl/smem_strobe_timer.sv
module smem_strobe_timer
    import smem_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] cfg_setup,
    input  logic [31:0] cfg_pulse,
    input  logic [31:0] cfg_cycle,
    input  logic [31:0] cfg_mode,
    input  logic        req_start,
    input  logic        req_write,
    input  logic        req_same_bank,
    input  logic        ext_wait,
    output logic        cs_n,
    output logic        rd_n,
    output logic        wr_n,
    output logic        xfer_edge,
    output logic        busy,
    output logic        done
);

    localparam int N_WIN = 2;   // window 0: chip select, window 1: direction strobe

    st_t  st_q, st_d;

    cnt_t cs_setup, cs_pulse, dir_setup, dir_pulse, cyc_len;
    logic ctl_on_strobe;
    logic hold;
    cnt_t win_setup [N_WIN];
    cnt_t win_pulse [N_WIN];
    logic [N_WIN-1:0] win_low;
    logic ctl_now;
    logic start_ok;
    flt_t tdf_len;
    wait_mode_e wmode;

    assign wmode   = wait_mode_e'(cfg_mode[5:4]);
    assign tdf_len = flt_t'(cfg_mode[19:16]) + flt_t'(1);

    smem_timing_sel u_sel (
        .cfg_setup    (cfg_setup),
        .cfg_pulse    (cfg_pulse),
        .cfg_cycle    (cfg_cycle),
        .cfg_ctl_sel  (cfg_mode[1:0]),
        .is_wr        (st_q.wr),
        .cs_setup     (cs_setup),
        .cs_pulse     (cs_pulse),
        .dir_setup    (dir_setup),
        .dir_pulse    (dir_pulse),
        .cyc_len      (cyc_len),
        .ctl_on_strobe(ctl_on_strobe)
    );

    assign win_setup[0] = cs_setup;
    assign win_pulse[0] = cs_pulse;
    assign win_setup[1] = dir_setup;
    assign win_pulse[1] = dir_pulse;

    for (genvar i = 0; i < N_WIN; i++) begin : g_win
        smem_strobe_win u_win (
            .en   (st_q.act),
            .cnt  (st_q.cnt),
            .setup(win_setup[i]),
            .pulse(win_pulse[i]),
            .low  (win_low[i])
        );
    end

    smem_wait_hold u_hold (
        .mode     (wmode),
        .ext_wait (ext_wait),
        .cnt      (st_q.cnt),
        .dir_setup(dir_setup),
        .dir_pulse(dir_pulse),
        .hold     (hold)
    );

    assign ctl_now  = ctl_on_strobe ? win_low[1] : win_low[0];
    assign start_ok = (st_q.flt == '0) || (cfg_mode[20] && (req_write || req_same_bank));

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.ctl_low = ctl_now;
        if (st_q.act) begin
            if (!hold) begin
                if (st_q.cnt == cyc_len - cnt_t'(1)) begin
                    st_d.act  = 1'b0;
                    st_d.done = 1'b1;
                    st_d.flt  = st_q.wr ? '0 : tdf_len;
                end else begin
                    st_d.cnt = st_q.cnt + cnt_t'(1);
                end
            end
        end else if (req_start && start_ok) begin
            st_d.act = 1'b1;
            st_d.wr  = req_write;
            st_d.cnt = '0;
            st_d.flt = '0;
        end else if (st_q.flt != '0) begin
            st_d.flt = st_q.flt - flt_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_n      = ~win_low[0];
    assign rd_n      = ~(win_low[1] & ~st_q.wr);
    assign wr_n      = ~(win_low[1] &  st_q.wr);
    assign xfer_edge = st_q.ctl_low & ~ctl_now;
    assign busy      = st_q.act | (st_q.flt != '0);
    assign done      = st_q.done;

    logic unused_mode_bits;
    assign unused_mode_bits = ^{cfg_mode[31:21], cfg_mode[15:6], cfg_mode[3:2]};

endmodule

// File: rtl/smem_strobe_timer_chk.sv
module smem_strobe_timer_chk
    import smem_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cfg_mode,
    input logic        ext_wait,
    input logic        cs_n,
    input logic        rd_n,
    input logic        wr_n,
    input logic        xfer_edge,
    input logic        busy,
    input logic        done,
    input st_t         st
);

    assert_done_strobes_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && rd_n && wr_n));

    assert_busy_when_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n || !rd_n || !wr_n) |-> busy);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_edge_after_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_edge |-> $past(!cs_n || !rd_n || !wr_n));

    assert_freeze_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st.act && cfg_mode[5:4] == 2'd2 && ext_wait) |=> (st.act && st.cnt == $past(st.cnt)));

    assert_float_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st.act && st.flt != '0 && !cfg_mode[20]) |=> !st.act);

endmodule

bind smem_strobe_timer smem_strobe_timer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_mode (cfg_mode),
    .ext_wait (ext_wait),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .xfer_edge(xfer_edge),
    .busy     (busy),
    .done     (done),
    .st       (st_q)
);

// File: tb/smem_strobe_timer_test.sv
module smem_strobe_timer_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [31:0] cfg_setup = '0, cfg_pulse = '0, cfg_cycle = '0, cfg_mode = '0;
    logic req_start = 1'b0, req_write = 1'b0, req_same_bank = 1'b0, ext_wait = 1'b0;
    logic cs_n, rd_n, wr_n, xfer_edge, busy, done;

    smem_strobe_timer uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_cycle(cfg_cycle), .cfg_mode(cfg_mode),
        .req_start(req_start), .req_write(req_write), .req_same_bank(req_same_bank),
        .ext_wait(ext_wait),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .xfer_edge(xfer_edge), .busy(busy), .done(done)
    );

    int n_chk = 0;
    int n_fail = 0;

    // ---------------- expected-value functions from the requirements
    function automatic int b_setup(input logic [7:0] f);
        return (f[5] ? 128 : 0) + int'(f[4:0]);
    endfunction
    function automatic int b_pulse(input logic [7:0] f);
        return (f[6] ? 256 : 0) + int'(f[5:0]);
    endfunction
    function automatic int b_cycle(input logic [15:0] f);
        int v;
        v = int'(f[8:7]) * 256 + int'(f[6:0]);
        return (v == 0) ? 1 : v;
    endfunction

    bit m_act = 0, m_wr = 0, m_done = 0, m_ctl = 0;
    int m_cnt = 0, m_flt = 0;

    function automatic bit m_in(input int s, input int p);
        return m_act && (m_cnt >= s) && (m_cnt < s + p);
    endfunction
    function automatic bit m_cs_low();
        return m_wr ? m_in(b_setup(cfg_setup[15:8]), b_pulse(cfg_pulse[15:8]))
                    : m_in(b_setup(cfg_setup[31:24]), b_pulse(cfg_pulse[31:24]));
    endfunction
    function automatic bit m_dir_low();
        return m_wr ? m_in(b_setup(cfg_setup[7:0]), b_pulse(cfg_pulse[7:0]))
                    : m_in(b_setup(cfg_setup[23:16]), b_pulse(cfg_pulse[23:16]));
    endfunction
    function automatic bit m_ctl_now();
        bit sel;
        sel = m_wr ? cfg_mode[1] : cfg_mode[0];
        return sel ? m_dir_low() : m_cs_low();
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_wr = 0; m_done = 0; m_ctl = 0; m_cnt = 0; m_flt = 0;
        end else begin
            bit nctl, hold;
            int ln, ds, dp;
            nctl   = m_ctl_now();
            m_done = 0;
            ln = m_wr ? b_cycle(cfg_cycle[15:0]) : b_cycle(cfg_cycle[31:16]);
            ds = m_wr ? b_setup(cfg_setup[7:0]) : b_setup(cfg_setup[23:16]);
            dp = m_wr ? b_pulse(cfg_pulse[7:0]) : b_pulse(cfg_pulse[23:16]);
            hold = (cfg_mode[5:4] == 2'd2 && ext_wait) ||
                   (cfg_mode[5:4] == 2'd3 && ext_wait && dp != 0 && m_cnt == ds + dp - 1);
            if (m_act) begin
                if (!hold) begin
                    if (m_cnt == ln - 1) begin
                        m_act = 0; m_done = 1;
                        m_flt = m_wr ? 0 : int'(cfg_mode[19:16]) + 1;
                    end else m_cnt++;
                end
            end else if (req_start && (m_flt == 0 || (cfg_mode[20] && (req_write || req_same_bank)))) begin
                m_act = 1; m_wr = req_write; m_cnt = 0; m_flt = 0;
            end else if (m_flt != 0) m_flt--;
            m_ctl = nctl;
        end
    end

    task automatic chk(input string req, input string nm, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, nm, got, exp);
        end
    endtask

    // lockstep comparison of every output in every clock
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1", "cs_n", int'(cs_n), int'(!m_cs_low()));
            chk("R2", "rd_n", int'(rd_n), int'(!(m_dir_low() && !m_wr)));
            chk("R4", "wr_n", int'(wr_n), int'(!(m_dir_low() && m_wr)));
            chk("R6", "done", int'(done), int'(m_done));
            chk("R9", "busy", int'(busy), int'(m_act || m_flt != 0));
            chk("R5", "xfer_edge", int'(xfer_edge), int'(m_ctl && !m_ctl_now()));
        end
    end

    task automatic settle();
        while (busy) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [31:0] s, input logic [31:0] p,
                           input logic [31:0] c, input logic [31:0] m);
        cfg_setup = s; cfg_pulse = p; cfg_cycle = c; cfg_mode = m;
    endtask

    // raises a request now, returns at the negedge showing done
    task automatic do_access(input logic wr, input logic same, input int ws, input int wl,
                             output int t_done, output int t_cs, output int n_cs,
                             output int n_st, output int n_ed);
        int k;
        k = 0; t_done = -1; t_cs = -1; n_cs = 0; n_st = 0; n_ed = 0;
        req_start = 1'b1; req_write = wr; req_same_bank = same;
        forever begin
            @(negedge clk);
            k++;
            if (m_act) req_start = 1'b0;
            if (!cs_n) begin n_cs++; if (t_cs < 0) t_cs = k; end
            if (!rd_n || !wr_n) n_st++;
            if (xfer_edge) n_ed++;
            ext_wait = (k >= ws) && (k < ws + wl);
            if (done) begin t_done = k; break; end
            if (k > 5000) break;
        end
        req_start = 1'b0;
        ext_wait = 1'b0;
    endtask

    function automatic logic [7:0] r_setup();
        return 8'($urandom_range(0, 6)) | (($urandom_range(0, 19) == 0) ? 8'h20 : 8'h00);
    endfunction
    function automatic logic [7:0] r_pulse();
        return 8'($urandom_range(0, 6)) | (($urandom_range(0, 24) == 0) ? 8'h40 : 8'h00);
    endfunction
    function automatic logic [15:0] r_cyc();
        return 16'($urandom_range(0, 24)) | (($urandom_range(0, 29) == 0) ? 16'h0080 : 16'h0000);
    endfunction
    function automatic logic [31:0] r_mode();
        return {11'b0, 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)), 10'b0,
                2'($urandom_range(0, 3)), 2'b0, 2'($urandom_range(0, 3))};
    endfunction

    initial begin : watchdog
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        int td, tc, nc, ns, ne;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", "cs_n in reset", int'(cs_n), 1);
        chk("R11", "rd_n in reset", int'(rd_n), 1);
        chk("R11", "wr_n in reset", int'(wr_n), 1);
        chk("R11", "busy in reset", int'(busy), 0);
        chk("R11", "done in reset", int'(done), 0);
        chk("R11", "xfer_edge in reset", int'(xfer_edge), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 coarse setup (128), R3 coarse read length 512
        set_cfg({8'h20, 24'h0}, {8'h04, 24'h0}, {16'h0100, 16'h0}, 32'h0);
        do_access(1'b0, 1'b0, 0, 0, td, tc, nc, ns, ne);
        chk("R1", "cs first low cycle", tc, 129);
        chk("R2", "cs low width", nc, 4);
        chk("R3", "read length 512", td, 513);

        // R2 coarse pulse 257 on write strobe, zero cs pulse; R3 length 639
        settle();
        set_cfg({24'h0, 8'h02}, {24'h0, 8'h41}, {16'h0, 16'h017F}, 32'h0);
        do_access(1'b1, 1'b0, 0, 0, td, tc, nc, ns, ne);
        chk("R2", "wr low width", ns, 257);
        chk("R2", "zero cs pulse never low", nc, 0);
        chk("R3", "write length 639", td, 640);

        // R3 zero length field acts as one
        settle();
        set_cfg(32'h0, 32'h0, 32'h0, 32'h0);
        do_access(1'b1, 1'b0, 0, 0, td, tc, nc, ns, ne);
        chk("R3", "zero length", td, 2);

        // R4 window past end of cycle is cut
        settle();
        set_cfg({8'h02, 24'h0}, {8'd20, 24'h0}, {16'd10, 16'h0}, 32'h0);
        do_access(1'b0, 1'b0, 0, 0, td, tc, nc, ns, ne);
        chk("R4", "cs low cut at cycle end", nc, 8);
        chk("R4", "length with overrun", td, 11);

        // R5 controlling strobe selection
        settle();
        set_cfg(32'h0, {8'd3, 8'd0, 16'h0}, {16'd6, 16'd6}, 32'h1);
        do_access(1'b0, 1'b0, 0, 0, td, tc, nc, ns, ne);
        chk("R5", "read ends on silent rd strobe", ne, 0);
        settle();
        cfg_mode = 32'h0;
        do_access(1'b0, 1'b0, 0, 0, td, tc, nc, ns, ne);
        chk("R5", "read ends on cs", ne, 1);
        settle();
        set_cfg(32'h1, 32'h2, {16'd6, 16'd6}, 32'h2);
        do_access(1'b1, 1'b0, 0, 0, td, tc, nc, ns, ne);
        chk("R5", "write ends on wr strobe", ne, 1);

        // R7 freeze: 5 stalled clocks
        settle();
        set_cfg(32'h0000_0002, 32'h0000_0003, {16'd10, 16'd10}, 32'h20);
        do_access(1'b1, 1'b0, 3, 5, td, tc, nc, ns, ne);
        chk("R7", "frozen length", td, 16);

        // R8 ready: hold on last strobe cycle
        settle();
        cfg_mode = 32'h30;
        do_access(1'b1, 1'b0, 1, 8, td, tc, nc, ns, ne);
        chk("R8", "ready length", td, 15);
        chk("R8", "ready wr low width", ns, 7);
        settle();
        cfg_mode = 32'h10;
        do_access(1'b1, 1'b0, 1, 8, td, tc, nc, ns, ne);
        chk("R8", "reserved mode ignores wait", td, 11);

        // R9 turnaround of 6 after a read, no bypass
        settle();
        set_cfg(32'h0, 32'h0, {16'd3, 16'd3}, 32'h0005_0000);
        do_access(1'b0, 1'b0, 0, 0, td, tc, nc, ns, ne);
        do_access(1'b1, 1'b0, 0, 0, td, tc, nc, ns, ne);
        chk("R9", "write after read waits", td, 10);
        do_access(1'b0, 1'b0, 0, 0, td, tc, nc, ns, ne);
        chk("R9", "no turnaround after write", td, 4);

        // R10 optimized bypass
        settle();
        cfg_mode = 32'h0015_0000;
        do_access(1'b0, 1'b0, 0, 0, td, tc, nc, ns, ne);
        do_access(1'b1, 1'b0, 0, 0, td, tc, nc, ns, ne);
        chk("R10", "write skips turnaround", td, 4);
        do_access(1'b0, 1'b0, 0, 0, td, tc, nc, ns, ne);
        do_access(1'b0, 1'b0, 0, 0, td, tc, nc, ns, ne);
        chk("R10", "other-bank read waits", td, 10);
        do_access(1'b0, 1'b1, 0, 0, td, tc, nc, ns, ne);
        chk("R10", "same-bank read skips", td, 4);

        // random phase, judged by the lockstep model
        for (int it = 0; it < 120; it++) begin
            if (it % 4 == 0) begin
                settle();
                set_cfg({r_setup(), r_setup(), r_setup(), r_setup()},
                        {r_pulse(), r_pulse(), r_pulse(), r_pulse()},
                        {r_cyc(), r_cyc()}, r_mode());
            end
            do_access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      $urandom_range(1, 10), $urandom_range(0, 5), td, tc, nc, ns, ne);
            chk("R3", "random access finished", int'(td > 0), 1);
            if ($urandom_range(0, 2) == 0) repeat ($urandom_range(1, 8)) @(negedge clk);
        end

        settle();
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule